// File: doc/BRIEF.md
# DMA Global Control and Fault Register

This block is the shared control and status word of a four-channel DMA controller. It keeps one master run bit that software sets and clears, and two sticky fault flags: one raised by the transfer engine when it detects a bad address, and one raised whenever a non-maskable interrupt arrives. Software cannot raise either flag. It can lower a flag only by writing 0 to it, and only after an earlier read showed that flag as 1.

The channel control registers sit outside this block. Each channel's enable bit and transfer-end bit arrive as inputs. From these bits, the run bit and the two flags, the block produces three outputs: a per-channel permit vector, a global suspend line that the engine samples before it starts any transfer cycle, and an error interrupt request that follows the address-fault flag.

Top module: `dmac_gctl`

## Requirements
- R1: After a synchronous active-low reset, the run bit and both fault flags are 0. As a result the read data, the permit vector and the error interrupt are all 0.
- R2: An address-fault event pulse sets the address-fault flag (read bit 2) at the next clock edge.
- R3: A non-maskable interrupt pulse sets the NMI flag (read bit 1) at the next clock edge, whatever the state of the run bit and the channels.
- R4: A CPU write of 1 to bit 1 or bit 2 never sets the corresponding flag.
- R5: A write with 0 in a flag's bit clears that flag only when the flag is armed. A flag becomes armed when a CPU read that is not paired with a write returns the flag as 1. A write of 0 with no such earlier read leaves the flag at 1.
- R6: Any CPU write disarms both flags, so a second write of 0 after an intervening write does not clear a flag.
- R7: When a flag's hardware event and a qualifying clearing write fall in the same cycle, the flag stays 1.
- R8: permit[i] is 1 only when the run bit is 1, channel i's enable is 1, its transfer-end bit is 0 and both fault flags are 0.
- R9: suspend is high, combinationally, whenever the run bit is 0, either flag is 1, or a fault event is present in the current cycle.
- R10: Read data carries the run bit in bit 0, the NMI flag in bit 1 and the address-fault flag in bit 2, with all other bits 0. A write loads the run bit from bit 0 of the write data.
- R11: The error interrupt request equals the address-fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | CPU read strobe; the read data is valid in the same cycle |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Register read value |
| addr_err_evt | input | 1 | Address-fault pulse from the transfer engine |
| nmi_evt | input | 1 | Non-maskable interrupt pulse |
| ch_en | input | 4 | Per-channel enable bits |
| ch_te | input | 4 | Per-channel transfer-end bits |
| ch_permit | output | 4 | Per-channel transfer permit |
| suspend | output | 1 | Global transfer suspend |
| err_irq | output | 1 | Address-fault interrupt request |

## Verification
Register state changes at the first rising edge after an input. The read data, the permit vector and the interrupt follow the registers and have no further delay, so each of them shows a stimulus one edge after it is applied. Suspend is the only output that responds in the same cycle as a fault event. The bench drives each cycle's inputs just after a falling edge. It compares every combinational output against its model state one nanosecond later, before the rising edge. It then advances its model across that edge, so each result is checked in the cycle it is due.

// File: rtl/dmac_gctl_pkg.sv
// Package: bit positions of the global control word and the flag state record.
// Assumes: the run bit and the two fault flags occupy the lowest three bits.
package dmac_gctl_pkg;
    localparam int unsigned RUN_BIT   = 0;
    localparam int unsigned NMI_BIT   = 1;
    localparam int unsigned AFLT_BIT  = 2;
    localparam int unsigned USED_BITS = 3;

    typedef struct packed {
        logic aflt;
        logic nmi;
        logic run;
    } gctl_state_t;
endpackage

// File: rtl/dmac_fault_flag.sv
// Sticky fault flag that hardware sets and software clears through read-then-write-0.
// Assumes: rd_req and wr_req are single-cycle strobes. When both are present, the
// write takes priority and the read does not arm the flag.
module dmac_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_req,
    input  logic wr_req,
    input  logic wr_val,
    output logic flag_q
);
    logic armed_q;
    logic clr_ok;

    // A clear qualifies only for a write of 0 while the flag is armed.
    assign clr_ok = wr_req && !wr_val && armed_q;

    // Flag register: the hardware event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_ok)  flag_q <= 1'b0;
    end

    // Arm register: armed by a read that sees 1, disarmed by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (wr_req)           armed_q <= 1'b0;
        else if (rd_req && flag_q) armed_q <= 1'b1;
    end

    // R7 (and R2/R3): an event leaves the flag at 1 even when a clear write arrives with it.
    p_set_dominates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !set_evt) |=> !flag_q);
    p_hold_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q) |=> flag_q);
    p_arm_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> flag_q);
endmodule

// File: rtl/dmac_chan_gate.sv
// Per-channel permit gating: a channel may run when the global run condition holds,
// the channel is enabled and it has not reached its transfer end.
// Assumes: ch_en and ch_te are stable register outputs from the channel controls.
module dmac_chan_gate #(
    parameter int unsigned N_CH = 4
) (
    input  logic            run_ok,
    input  logic [N_CH-1:0] ch_en,
    input  logic [N_CH-1:0] ch_te,
    output logic [N_CH-1:0] ch_permit
);
    // One AND gate per channel.
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign ch_permit[i] = run_ok & ch_en[i] & ~ch_te[i];
    end
endmodule

// File: rtl/dmac_gctl.sv
// Top: global control word of the DMA controller. It holds the run bit and the
// two fault flags, and it drives the channel permits, suspend and the error interrupt.
// Assumes: one register address, so cpu_rd and cpu_wr already mean "selected".
module dmac_gctl
    import dmac_gctl_pkg::*;
#(
    parameter int unsigned N_CH   = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              addr_err_evt,
    input  logic              nmi_evt,
    input  logic [N_CH-1:0]   ch_en,
    input  logic [N_CH-1:0]   ch_te,
    output logic [N_CH-1:0]   ch_permit,
    output logic              suspend,
    output logic              err_irq
);
    localparam int unsigned PAD_W = DATA_W - USED_BITS;

    gctl_state_t st;
    logic        run_ok;

    // Run bit: loaded from write data bit 0 on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      st.run <= 1'b0;
        else if (cpu_wr) st.run <= cpu_wdata[RUN_BIT];
    end

    dmac_fault_flag u_nmi_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (nmi_evt),
        .rd_req  (cpu_rd),
        .wr_req  (cpu_wr),
        .wr_val  (cpu_wdata[NMI_BIT]),
        .flag_q  (st.nmi)
    );

    dmac_fault_flag u_aflt_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (addr_err_evt),
        .rd_req  (cpu_rd),
        .wr_req  (cpu_wr),
        .wr_val  (cpu_wdata[AFLT_BIT]),
        .flag_q  (st.aflt)
    );

    // Global run condition from the registered state.
    assign run_ok = st.run & ~st.nmi & ~st.aflt;

    dmac_chan_gate #(.N_CH(N_CH)) u_gate (
        .run_ok    (run_ok),
        .ch_en     (ch_en),
        .ch_te     (ch_te),
        .ch_permit (ch_permit)
    );

    // Suspend also covers events in the current cycle, so no new cycle can start.
    assign suspend   = ~run_ok | nmi_evt | addr_err_evt;
    assign err_irq   = st.aflt;
    assign cpu_rdata = {{PAD_W{1'b0}}, st};

    p_ae_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_evt |=> cpu_rdata[AFLT_BIT]);
    p_nmi_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |=> cpu_rdata[NMI_BIT]);
    p_permit_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_permit) |-> (cpu_rdata[RUN_BIT] && !cpu_rdata[NMI_BIT] && !cpu_rdata[AFLT_BIT]));
    p_stopped_suspends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata[RUN_BIT] |-> suspend);
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> $past(addr_err_evt));
endmodule

// File: tb/dmac_gctl_tb.sv
// Bench: directed corner cases followed by seeded random cycles, all compared
// against a cycle model written from the requirements.
module dmac_gctl_tb;
    localparam int N_CH = 4;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          addr_err_evt = 1'b0, nmi_evt = 1'b0;
    logic [N_CH-1:0] ch_en = '0, ch_te = '0;
    logic [N_CH-1:0] ch_permit;
    logic          suspend, err_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state.
    bit m_run, m_nmi, m_ae, m_arm_nmi, m_arm_ae;

    always #2 clk = ~clk;

    dmac_gctl #(.N_CH(N_CH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .addr_err_evt(addr_err_evt), .nmi_evt(nmi_evt),
        .ch_en(ch_en), .ch_te(ch_te), .ch_permit(ch_permit),
        .suspend(suspend), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit [N_CH-1:0] exp_permit(input bit run, input bit nmi, input bit ae,
                                                 input bit [N_CH-1:0] en, input bit [N_CH-1:0] te);
        return (run && !nmi && !ae) ? (en & ~te) : '0;
    endfunction

    // One cycle: drive the inputs, check the outputs before the edge, then step the model.
    task automatic apply(input string req, input bit rd, input bit wr, input logic [DW-1:0] wd,
                         input bit ae, input bit nmi, input bit [N_CH-1:0] en, input bit [N_CH-1:0] te);
        bit nx_nmi, nx_ae, nx_an, nx_aa;
        cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        addr_err_evt = ae; nmi_evt = nmi; ch_en = en; ch_te = te;
        #1;
        check(req,   cpu_rdata, {29'd0, m_ae, m_nmi, m_run});
        check("R8",  DW'(ch_permit), DW'(exp_permit(m_run, m_nmi, m_ae, en, te)));
        check("R9",  DW'(suspend), DW'(!m_run || m_nmi || m_ae || ae || nmi));
        check("R11", DW'(err_irq), DW'(m_ae));
        nx_nmi = nmi ? 1'b1 : ((wr && !wd[1] && m_arm_nmi) ? 1'b0 : m_nmi);
        nx_ae  = ae  ? 1'b1 : ((wr && !wd[2] && m_arm_ae)  ? 1'b0 : m_ae);
        nx_an  = wr ? 1'b0 : ((rd && m_nmi) ? 1'b1 : m_arm_nmi);
        nx_aa  = wr ? 1'b0 : ((rd && m_ae)  ? 1'b1 : m_arm_ae);
        @(posedge clk);
        if (wr) m_run = wd[0];
        m_nmi = nx_nmi; m_ae = nx_ae; m_arm_nmi = nx_an; m_arm_ae = nx_aa;
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        apply(req, 0, 0, '0, 0, 0, 4'hF, 4'h0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        s = $urandom(1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs while reset is still held.
        check("R1", cpu_rdata, '0);
        check("R1", DW'(ch_permit), '0);
        check("R1", DW'(err_irq), '0);
        rst_n = 1'b1;
        idle("R1");
        // R10: run bit from write bit 0, layout of the read word.
        apply("R10", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R10");
        // R4: writing ones to the flag bits sets nothing.
        apply("R4", 0, 1, 32'hFFFF_FFFF, 0, 0, 4'hF, 4'h0);
        idle("R4");
        // R8: permit patterns with the run bit set and no faults.
        apply("R8", 0, 0, '0, 0, 0, 4'b1010, 4'b0010);
        apply("R8", 0, 0, '0, 0, 0, 4'b1111, 4'b0101);
        // R3 and R9: an NMI pulse raises suspend at once and the flag on the next edge.
        apply("R3", 0, 0, '0, 0, 1, 4'hF, 4'h0);
        idle("R3");
        // R5: a clear write without an earlier read leaves the flag set.
        apply("R5", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R5");
        apply("R5", 1, 0, '0, 0, 0, 4'hF, 4'h0);
        apply("R5", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R5");
        // R6: an intervening write disarms the flag.
        apply("R6", 0, 0, '0, 0, 1, 4'hF, 4'h0);
        apply("R6", 1, 0, '0, 0, 0, 4'hF, 4'h0);
        apply("R6", 0, 1, 32'h3, 0, 0, 4'hF, 4'h0);
        apply("R6", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R6");
        apply("R6", 1, 0, '0, 0, 0, 4'hF, 4'h0);
        apply("R6", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R6");
        // R2 and R11: an address fault sets the flag and the interrupt.
        apply("R2", 0, 0, '0, 1, 0, 4'hF, 4'h0);
        idle("R2");
        // R7: an event in the same cycle as a qualifying clear keeps the flag at 1.
        apply("R7", 1, 0, '0, 0, 0, 4'hF, 4'h0);
        apply("R7", 0, 1, 32'h1, 1, 0, 4'hF, 4'h0);
        idle("R7");
        apply("R7", 1, 0, '0, 0, 0, 4'hF, 4'h0);
        apply("R7", 0, 1, 32'h1, 0, 0, 4'hF, 4'h0);
        idle("R7");
        // R3: the NMI flag sets even with the run bit clear.
        apply("R3", 0, 1, 32'h0, 0, 0, 4'hF, 4'h0);
        apply("R3", 0, 0, '0, 0, 1, 4'h0, 4'h0);
        idle("R3");
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            apply("R10", ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom,
                  ($urandom % 12) == 0, ($urandom % 12) == 0,
                  4'($urandom), 4'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule